// File: doc/BRIEF.md
# Flash Protection and Command Gatekeeper

This block stands between a command source and an on-chip flash array. It holds a protection register that marks a protected window at the top of the array. It holds a configuration register with two interrupt enables and a key-access mode bit. It also holds a status register with buffer-empty, all-complete and protection-violation flags.

Program, sector-erase and mass-erase requests arrive on a valid/ready stream. Each request is checked against the protected window. A request that passes goes into a one-entry command buffer, and from there it is launched to the array through a start/done handshake. A request that fails is dropped and sets a sticky violation flag.

When key-access mode is on, the same stream is steered out of the block on a separate key port. In that mode no command is started.

The protection value is taken from a stored configuration byte while reset is asserted. After reset the value can only ever widen the protected window.

Top module: `flash_guard`

## Requirements
- R1: A register write to PROT (reg_addr 1) takes effect only when the new value gives a strictly larger protected size than the current value. A smaller or equal size is ignored and leaves the register unchanged. Encoding: bit 7 = 1 means nothing is protected (size 0). Otherwise the top (bits[6:0]+1) KB of the array are protected.
- R2: While rst_n is low, PROT is loaded from prot_seed. After reset, reading reg_addr 1 returns that seed.
- R3: A program (cmd_op 00) or sector-erase (cmd_op 01) request is refused when its address is at or above the boundary, where the boundary is 2^ADDR_W minus the protected size. A refused request never produces arr_start and sets the violation flag (STAT bit 5). An address one below the boundary is issued.
- R4: A mass-erase request (cmd_op 1x) is refused and sets the violation flag whenever PROT bit 7 is 0. When PROT bit 7 is 1, the mass erase is issued.
- R5: The violation flag is sticky. Writing STAT (reg_addr 2) with bit 5 = 1 clears it, and a write with bit 5 = 0 leaves it set. While the flag is set, cmd_ready is 0 in command mode.
- R6: irq_cbe equals CFG bit 7 AND the buffer-empty flag (STAT bit 7).
- R7: STAT bit 6 (all complete) is 1 only when the buffer is empty and the array has reported arr_done for the last launched command. irq_cc equals CFG bit 6 AND that flag.
- R8: With CFG bit 5 = 1, key_valid follows cmd_valid, key_addr and key_data follow the command fields, and cmd_ready follows key_ready. No command is buffered or started, and no violation is raised.
- R9: CFG (reg_addr 0) stores bits 7, 6 and 5. Bits 4..0 always read 0, and CFG resets to 0.
- R10: A request accepted at clock edge k makes cmd_ready and STAT bit 7 low after edge k. The array command pulses arr_start for exactly one cycle after edge k+1, provided the array is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_seed | input | 8 | Stored protection byte, loaded during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 CFG, 1 PROT, 2 STAT |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request ready |
| cmd_op | input | 2 | 00 program, 01 sector erase, 1x mass erase |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | DATA_W | Program data or key word |
| key_valid | output | 1 | Key word valid (key-access mode) |
| key_ready | input | 1 | Key consumer ready |
| key_addr | output | ADDR_W | Key word address |
| key_data | output | DATA_W | Key word |
| arr_start | output | 1 | One-cycle launch pulse to the array |
| arr_op | output | 2 | Launched operation |
| arr_addr | output | ADDR_W | Launched address |
| arr_data | output | DATA_W | Launched data |
| arr_done | input | 1 | Array finished the launched command |
| irq_cbe | output | 1 | Buffer-empty interrupt request |
| irq_cc | output | 1 | All-complete interrupt request |

## Verification
Protection checking is driven with program addresses that sit exactly on the boundary and one byte below it. This pins the comparison to an at-or-above rule and catches an off-by-one in either direction. A sector erase at the top address is also tried.

Protection writes are tried with a smaller size, with the open code, with an equal value and with a larger value. Only the strictly larger value may change the register.

Mass erase is issued once with a protected window and once with an open window. A violation is cleared with a zero write and then with a one write, which separates a sticky write-one-to-clear flag from a plain writable bit.

Key mode is exercised with key_ready held low and then raised, using an address inside the protected window. This shows that the steered stream cannot create commands or violations.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] RA_CFG  = 2'd0;
  localparam logic [1:0] RA_PROT = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  localparam logic [1:0] OP_PROG   = 2'b00;
  localparam logic [1:0] OP_SERASE = 2'b01;

  localparam int CFG_CBEIE = 7;
  localparam int CFG_CCIE  = 6;
  localparam int CFG_KEY   = 5;

  localparam int ST_CBE  = 7;
  localparam int ST_CC   = 6;
  localparam int ST_VIOL = 5;

  // protected size in 1 KB steps: open code -> 0, else field + 1
  function automatic logic [7:0] prot_units(input logic [7:0] v);
    prot_units = v[7] ? 8'd0 : ({1'b0, v[6:0]} + 8'd1);
  endfunction
endpackage

// File: rtl/fg_prot_reg.sv
module fg_prot_reg
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        seed,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        prot_q,
  output logic              any_prot,
  output logic              hit
);
  localparam int EXT_W = ADDR_W + 1;
  localparam logic [EXT_W-1:0] TOP = EXT_W'(1) << ADDR_W;

  logic             grows;
  logic [EXT_W-1:0] span;
  logic [EXT_W-1:0] boundary;

  assign grows    = prot_units(wr_data) > prot_units(prot_q);
  assign span     = EXT_W'(prot_units(prot_q)) << STEP_W;
  assign boundary = TOP - span;
  assign any_prot = !prot_q[7];
  assign hit      = any_prot && ({1'b0, chk_addr} >= boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               prot_q <= seed;
    else if (wr_en && grows)  prot_q <= wr_data;
  end

  // R1: any change of the register must be a strict enlargement
  assert_prot_grow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q != $past(prot_q)) |-> (prot_units(prot_q) > prot_units($past(prot_q))));
endmodule

// File: rtl/fg_cmd_queue.sv
module fg_cmd_queue #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_hit,
  input  logic              any_prot,
  input  logic              viol_clr,
  output logic              arr_start,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  input  logic              arr_done,
  output logic              buf_empty,
  output logic              all_done,
  output logic              viol
);
  logic              buf_full;
  logic              active;
  logic [1:0]        buf_op;
  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic              accept;
  logic              refuse;
  logic              launch;

  assign req_ready = !buf_full && !viol;
  assign accept    = req_valid && req_ready;
  assign refuse    = accept && (req_op[1] ? any_prot : req_hit);
  assign launch    = buf_full && !active;
  assign buf_empty = !buf_full;
  assign all_done  = !buf_full && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol <= 1'b0;
    end else if (refuse) begin
      viol <= 1'b1;
    end else if (viol_clr) begin
      viol <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full  <= 1'b0;
      active    <= 1'b0;
      arr_start <= 1'b0;
      buf_op    <= '0;
      buf_addr  <= '0;
      buf_data  <= '0;
      arr_op    <= '0;
      arr_addr  <= '0;
      arr_data  <= '0;
    end else begin
      arr_start <= 1'b0;
      if (arr_done) active <= 1'b0;
      if (accept && !refuse) begin
        buf_full <= 1'b1;
        buf_op   <= req_op;
        buf_addr <= req_addr;
        buf_data <= req_data;
      end else if (launch) begin
        buf_full  <= 1'b0;
        active    <= 1'b1;
        arr_start <= 1'b1;
        arr_op    <= buf_op;
        arr_addr  <= buf_addr;
        arr_data  <= buf_data;
      end
    end
  end

  // R3: a protected program or sector erase never enters the buffer
  assert_block_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_op[1] && req_hit) |=> (viol && !buf_full));

  // R4: mass erase with any protected sector is refused
  assert_mass_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op[1] && any_prot) |=> (viol && !buf_full));

  // R5: violation flag stays set until cleared
  assert_viol_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !viol_clr) |=> viol);

  // R10: a launch pulse always drains a previously full buffer
  assert_launch_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> ($past(buf_full) && !buf_full && active));
endmodule

// File: rtl/fg_cfg_regs.sv
module fg_cfg_regs
  import flash_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [2:0] wr_hi,
  input  logic [7:0] prot_q,
  input  logic       buf_empty,
  input  logic       all_done,
  input  logic       viol,
  output logic       cbe_en,
  output logic       cc_en,
  output logic       key_mode,
  output logic       prot_wr,
  output logic       viol_clr,
  output logic [7:0] reg_rdata
);
  logic [2:0] cfg_q;

  assign cbe_en   = cfg_q[2];
  assign cc_en    = cfg_q[1];
  assign key_mode = cfg_q[0];
  assign prot_wr  = reg_wr && (reg_addr == RA_PROT);
  // wr_hi[0] carries data bit 5, the violation clear bit
  assign viol_clr = reg_wr && (reg_addr == RA_STAT) && wr_hi[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cfg_q <= 3'b000;
    else if (reg_wr && reg_addr == RA_CFG)   cfg_q <= wr_hi;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CFG:  reg_rdata = {cfg_q, 5'b0};
      RA_PROT: reg_rdata = prot_q;
      RA_STAT: begin
        reg_rdata[ST_CBE]  = buf_empty;
        reg_rdata[ST_CC]   = all_done;
        reg_rdata[ST_VIOL] = viol;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R9: reserved configuration bits never read back as 1
  assert_cfg_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_CFG) |-> (reg_rdata[4:0] == 5'b0));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        prot_seed,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              key_valid,
  input  logic              key_ready,
  output logic [ADDR_W-1:0] key_addr,
  output logic [DATA_W-1:0] key_data,
  output logic              arr_start,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  input  logic              arr_done,
  output logic              irq_cbe,
  output logic              irq_cc
);
  logic [7:0] prot_q;
  logic       any_prot, hit;
  logic       cbe_en, cc_en, key_mode, prot_wr, viol_clr;
  logic       q_valid, q_ready;
  logic       buf_empty, all_done, viol;

  fg_prot_reg #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_prot (
    .clk(clk), .rst_n(rst_n), .seed(prot_seed),
    .wr_en(prot_wr), .wr_data(reg_wdata), .chk_addr(cmd_addr),
    .prot_q(prot_q), .any_prot(any_prot), .hit(hit)
  );

  fg_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wr_hi(reg_wdata[7:5]), .prot_q(prot_q), .buf_empty(buf_empty),
    .all_done(all_done), .viol(viol), .cbe_en(cbe_en), .cc_en(cc_en),
    .key_mode(key_mode), .prot_wr(prot_wr), .viol_clr(viol_clr),
    .reg_rdata(reg_rdata)
  );

  assign q_valid   = cmd_valid && !key_mode;
  assign key_valid = cmd_valid && key_mode;
  assign key_addr  = cmd_addr;
  assign key_data  = cmd_data;
  assign cmd_ready = key_mode ? key_ready : q_ready;

  fg_cmd_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .req_valid(q_valid), .req_ready(q_ready),
    .req_op(cmd_op), .req_addr(cmd_addr), .req_data(cmd_data),
    .req_hit(hit), .any_prot(any_prot), .viol_clr(viol_clr),
    .arr_start(arr_start), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_done(arr_done), .buf_empty(buf_empty),
    .all_done(all_done), .viol(viol)
  );

  assign irq_cbe = cbe_en && buf_empty;
  assign irq_cc  = cc_en && all_done;

  // R8: in key mode the command stream leaves no violation behind
  assert_key_no_viol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_mode && !viol) |=> !viol);
endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
  localparam int AW = 17;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    prot_seed = 8'h03;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          key_valid;
  logic          key_ready = 1'b0;
  logic [AW-1:0] key_addr;
  logic [DW-1:0] key_data;
  logic          arr_start;
  logic [1:0]    arr_op;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic          arr_done = 1'b0;
  logic          irq_cbe, irq_cc;

  int total = 0;
  int bad = 0;
  int starts = 0;
  int tmr = 0;
  logic [1:0]    last_op = '0;
  logic [AW-1:0] last_addr = '0;

  always #2 clk = ~clk;

  flash_guard u_flash_guard (
    .clk(clk), .rst_n(rst_n), .prot_seed(prot_seed), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .key_valid(key_valid),
    .key_ready(key_ready), .key_addr(key_addr), .key_data(key_data),
    .arr_start(arr_start), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_done(arr_done), .irq_cbe(irq_cbe), .irq_cc(irq_cc)
  );

  // array model: done three cycles after each start
  always @(negedge clk) begin
    if (arr_done) arr_done = 1'b0;
    if (tmr > 0) begin
      tmr = tmr - 1;
      if (tmr == 0) arr_done = 1'b1;
    end
    if (arr_start) begin
      starts = starts + 1;
      last_op = arr_op;
      last_addr = arr_addr;
      tmr = 3;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] seed);
    @(negedge clk);
    rst_n = 1'b0;
    prot_seed = seed;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = 32'hA5A5_0000 | 32'(a);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset(8'h03);
    reg_read(2'd1, v); check(v == 8'h03, "R2 seed load", v, 8'h03);
    reg_read(2'd0, v); check(v == 8'h00, "R9 cfg reset", v, 8'h00);
    reg_read(2'd2, v); check(v == 8'hC0, "R7 stat idle", v, 8'hC0);
    check(irq_cbe == 0 && irq_cc == 0, "R6 irq off at reset", {irq_cbe, irq_cc}, 0);
    check(cmd_ready == 1, "R5 ready after reset", cmd_ready, 1);
  endtask

  task automatic t_boundary();
    int s;
    logic [7:0] v;
    s = starts;
    send(2'b00, 17'h1F000);
    reg_read(2'd2, v);
    check(v[5] == 1, "R3 boundary prog viol", v[5], 1);
    check(starts == s, "R3 boundary prog not issued", starts - s, 0);
    reg_write(2'd2, 8'h20);
    s = starts;
    send(2'b00, 17'h1EFFF);
    check(starts == s + 1, "R3 below boundary issued", starts - s, 1);
    check(last_addr == 17'h1EFFF, "R3 issued address", last_addr, 17'h1EFFF);
    reg_read(2'd2, v);
    check(v[5] == 0, "R3 below boundary no viol", v[5], 0);
    s = starts;
    send(2'b01, 17'h1FFFF);
    reg_read(2'd2, v);
    check(v[5] == 1 && starts == s, "R3 sector erase blocked", v[5], 1);
  endtask

  task automatic t_sticky();
    int s;
    logic [7:0] v;
    reg_write(2'd2, 8'h00);
    reg_read(2'd2, v);
    check(v[5] == 1, "R5 zero write keeps viol", v[5], 1);
    check(cmd_ready == 0, "R5 ready low while viol", cmd_ready, 0);
    s = starts;
    send(2'b00, 17'h00010);
    check(starts == s, "R5 no command while viol", starts - s, 0);
    reg_write(2'd2, 8'h20);
    reg_read(2'd2, v);
    check(v[5] == 0, "R5 one write clears", v[5], 0);
    check(cmd_ready == 1, "R5 ready back", cmd_ready, 1);
  endtask

  task automatic t_grow();
    logic [7:0] v;
    int s;
    reg_write(2'd1, 8'h01); reg_read(2'd1, v);
    check(v == 8'h03, "R1 shrink ignored", v, 8'h03);
    reg_write(2'd1, 8'h80); reg_read(2'd1, v);
    check(v == 8'h03, "R1 open ignored", v, 8'h03);
    reg_write(2'd1, 8'h03); reg_read(2'd1, v);
    check(v == 8'h03, "R1 equal kept", v, 8'h03);
    reg_write(2'd1, 8'h07); reg_read(2'd1, v);
    check(v == 8'h07, "R1 grow accepted", v, 8'h07);
    s = starts;
    send(2'b00, 17'h1EFFF);
    reg_read(2'd2, v);
    check(v[5] == 1 && starts == s, "R3 new boundary blocks", v[5], 1);
    reg_write(2'd2, 8'h20);
  endtask

  task automatic t_mass();
    int s;
    logic [7:0] v;
    s = starts;
    send(2'b10, 17'h0);
    reg_read(2'd2, v);
    check(v[5] == 1 && starts == s, "R4 mass refused", v[5], 1);
    do_reset(8'h80);
    s = starts;
    send(2'b11, 17'h0);
    check(starts == s + 1 && last_op[1] == 1, "R4 mass issued when open", starts - s, 1);
  endtask

  task automatic t_timing();
    logic [7:0] v;
    int s;
    s = starts;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 17'h00100;
    @(negedge clk);
    cmd_valid = 1'b0;
    reg_addr = 2'd2;
    #1 v = reg_rdata;
    check(arr_start == 0 && cmd_ready == 0 && v[7] == 0, "R10 buffered", {arr_start, cmd_ready, v[7]}, 0);
    @(negedge clk);
    check(arr_start == 1, "R10 start next cycle", arr_start, 1);
    @(negedge clk);
    check(arr_start == 0, "R10 single pulse", arr_start, 0);
    repeat (8) @(negedge clk);
    check(starts == s + 1, "R10 one launch", starts - s, 1);
  endtask

  task automatic t_irq();
    reg_write(2'd0, 8'hC0);
    @(negedge clk);
    check(irq_cbe == 1 && irq_cc == 1, "R6 R7 idle irq", {irq_cbe, irq_cc}, 3);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 17'h00200;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(irq_cbe == 0 && irq_cc == 0, "R6 buffer full irq", {irq_cbe, irq_cc}, 0);
    @(negedge clk);
    check(irq_cbe == 1 && irq_cc == 0, "R7 busy no complete", {irq_cbe, irq_cc}, 2);
    repeat (8) @(negedge clk);
    check(irq_cc == 1, "R7 complete after done", irq_cc, 1);
    reg_write(2'd0, 8'h00);
    @(negedge clk);
    check(irq_cbe == 0 && irq_cc == 0, "R6 R7 disabled", {irq_cbe, irq_cc}, 0);
  endtask

  task automatic t_key();
    logic [7:0] v;
    int s;
    do_reset(8'h7F);
    reg_write(2'd0, 8'hFF);
    reg_read(2'd0, v);
    check(v == 8'hE0, "R9 reserved read zero", v, 8'hE0);
    reg_write(2'd0, 8'h20);
    s = starts;
    @(negedge clk);
    key_ready = 1'b0;
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 17'h1FFFF; cmd_data = 32'hDEAD_BEEF;
    #1;
    check(key_valid == 1 && cmd_ready == 0, "R8 key stalls", {key_valid, cmd_ready}, 2);
    check(key_addr == 17'h1FFFF && key_data == 32'hDEAD_BEEF, "R8 key fields", key_data, 32'hDEAD_BEEF);
    @(negedge clk);
    key_ready = 1'b1;
    #1 check(cmd_ready == 1, "R8 ready follows key", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0; key_ready = 1'b0;
    repeat (8) @(negedge clk);
    reg_read(2'd2, v);
    check(starts == s && v[5] == 0, "R8 no command no viol", starts - s, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_boundary();
    t_sticky();
    t_grow();
    t_mass();
    t_timing();
    t_irq();
    t_key();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule